// File: doc/BRIEF.md
# UART Modem Handshake Unit

This block is the modem-handshake slice of a UART. It watches four active-low inputs from a modem (clear-to-send, data-set-ready, ring indicator, carrier detect) and drives two active-low outputs (request-to-send, data-terminal-ready). A small register port exposes a control register, a status register, an interrupt-enable register and a receive-fill trigger level. The status register reports the present level of each modem line and a sticky flag per line that records any change since the status register was last read. A modem-status interrupt is raised whenever a change flag is pending and the interrupt is enabled.

Two automatic flow-control modes sit beside the manual ones. With automatic RTS, the request-to-send pin follows the receive FIFO fill level against a programmed trigger. With automatic CTS, clear-to-send gates a transmit-allow output and stops acting as an interrupt source. A loop-back mode drives the outputs inactive and feeds the status levels from control bits instead of the pins, so software can test the handshake path without a modem attached.

Top module: `modem_ctrl_unit`

## Requirements
- R1: After reset, rtsN and dtrN are 1, modemIrq is 0, txAllow is 1, and the status register (address 1) reads 0x00.
- R2: Status bits 4, 5, 6, 7 hold the inverted levels of ctsN, dsrN, riN, dcdN; a pin change applied before clock edge k shows up in the status register after edge k+2 (two synchronizer flops plus the level register).
- R3: Status bits 0, 1, 2, 3 are set on any change of the CTS, DSR, RI, DCD level respectively, stay set while the status register is not read, and are cleared by a status read (rdEn high with addr 1) at the edge of that read.
- R4: A level change that lands on the same edge as a status read leaves its change flag set, so the next read reports it.
- R5: modemIrq is 1 exactly when interrupt-enable bit 3 (address 2) is 1 and at least one counted change flag is set.
- R6: With control bit 7 (auto-CTS) set, the CTS change flag does not raise modemIrq and txAllow equals the CTS level (1 when ctsN is low); with bit 7 clear, txAllow is 1.
- R7: Outside loop-back and auto-RTS, dtrN is the inverse of control bit 0 and rtsN the inverse of control bit 1, one cycle after the control register changes.
- R8: With control bit 4 (loop-back) set, rtsN and dtrN are 1, status levels come from control bits (CTS from bit 1, DSR from bit 0, RI from bit 2, DCD from bit 3), and the external modem pins have no effect on the status register.
- R9: With control bit 6 (auto-RTS) set and loop-back clear, rtsN is 1 when rxFill is at or above the trigger level (address 3) and 0 when below, one cycle after rxFill changes.
- R10: The control (address 0), interrupt-enable (address 2) and trigger (address 3, low FILL_W bits) registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears change flags on status reads) |
| addr | input | 2 | Register address: 0 control, 1 status, 2 interrupt enable, 3 trigger |
| wrData | input | DATA_W (8) | Write data |
| rdData | output | DATA_W (8) | Read data for the addressed register |
| ctsN | input | 1 | Clear-to-send from modem, active low |
| dsrN | input | 1 | Data-set-ready from modem, active low |
| riN | input | 1 | Ring indicator from modem, active low |
| dcdN | input | 1 | Carrier detect from modem, active low |
| rxFill | input | FILL_W (5) | Receive FIFO fill level for auto-RTS |
| rtsN | output | 1 | Request-to-send, active low |
| dtrN | output | 1 | Data-terminal-ready, active low |
| txAllow | output | 1 | Transmitter may send |
| modemIrq | output | 1 | Modem-status interrupt |

## Verification
The hardest case to reach from the ports is a line change whose flag sets on the very edge that a status read clears the flags. The stimulus gets there by counting the synchronizer latency: it drives the pin on a falling edge, lets exactly two rising edges pass, and then asserts the status read so the clearing edge coincides with the level register update. It then reads again and expects the flag still set. Loop-back is also awkward because entering and leaving it changes the levels, so each loop-back step reads and checks the flags that the mode switch itself produced.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

  localparam int NUM_LINES = 4;

  // register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IER  = 2'd2;
  localparam logic [1:0] ADDR_TRIG = 2'd3;

  // control register bit positions
  localparam int CTRL_DTR  = 0;
  localparam int CTRL_RTS  = 1;
  localparam int CTRL_AUXA = 2;
  localparam int CTRL_AUXB = 3;
  localparam int CTRL_LOOP = 4;
  localparam int CTRL_ARTS = 6;
  localparam int CTRL_ACTS = 7;

  // interrupt enable bit
  localparam int IER_MODEM = 3;

  // line index inside level / flag vectors
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  typedef struct packed {
    logic       wrCtrl;
    logic       wrIer;
    logic       wrTrig;
    logic       rdStatus;
    logic [1:0] sel;
  } mcuStrobeT;

endpackage

// File: rtl/mcu_sync.sv
module mcu_sync #(
  parameter int   WIDTH   = 4,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= {WIDTH{RST_VAL}};
          else       stage[0] <= dIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= {WIDTH{RST_VAL}};
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
  import mcu_pkg::*;
(
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  output mcuStrobeT  strobes
);

  always_comb begin
    strobes          = '0;
    strobes.sel      = addr;
    strobes.wrCtrl   = wrEn && (addr == ADDR_CTRL);
    strobes.wrIer    = wrEn && (addr == ADDR_IER);
    strobes.wrTrig   = wrEn && (addr == ADDR_TRIG);
    strobes.rdStatus = rdEn && (addr == ADDR_STAT);
  end

endmodule

// File: rtl/mcu_datapath.sv
module mcu_datapath
  import mcu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FILL_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_RST    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mcuStrobeT            strobes,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] pinsN,
  input  logic [FILL_W-1:0]    rxFill,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rtsN,
  output logic                 dtrN,
  output logic                 txAllow,
  output logic                 modemIrq,
  output logic [DATA_W-1:0]    ctrlReg,
  output logic [DATA_W-1:0]    ierReg,
  output logic [FILL_W-1:0]    trigReg,
  output logic [NUM_LINES-1:0] flagReg
);

  localparam int PAD_W = DATA_W - FILL_W;

  logic [NUM_LINES-1:0] pinsSyncN;
  logic [NUM_LINES-1:0] lvlNext;
  logic [NUM_LINES-1:0] lvlReg;
  logic [NUM_LINES-1:0] lineDelta;
  logic [NUM_LINES-1:0] irqMask;
  logic                 loopOn;
  logic                 autoRts;
  logic                 autoCts;
  logic                 fillHigh;

  mcu_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (pinsN),
    .dOut (pinsSyncN)
  );

  assign loopOn  = ctrlReg[CTRL_LOOP];
  assign autoRts = ctrlReg[CTRL_ARTS];
  assign autoCts = ctrlReg[CTRL_ACTS];

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ierReg  <= '0;
      trigReg <= FILL_W'(TRIG_RST);
    end else begin
      if (strobes.wrCtrl) ctrlReg <= wrData;
      if (strobes.wrIer)  ierReg  <= wrData;
      if (strobes.wrTrig) trigReg <= wrData[FILL_W-1:0];
    end
  end

  // line level source: pins or loop-back control bits
  always_comb begin
    if (loopOn) begin
      lvlNext[LN_CTS] = ctrlReg[CTRL_RTS];
      lvlNext[LN_DSR] = ctrlReg[CTRL_DTR];
      lvlNext[LN_RI]  = ctrlReg[CTRL_AUXA];
      lvlNext[LN_DCD] = ctrlReg[CTRL_AUXB];
    end else begin
      lvlNext = ~pinsSyncN;
    end
  end

  assign lineDelta = lvlNext ^ lvlReg;

  // per-line level and sticky change flag
  genvar ln;
  generate
    for (ln = 0; ln < NUM_LINES; ln++) begin : gLine
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lvlReg[ln]  <= 1'b0;
          flagReg[ln] <= 1'b0;
        end else begin
          lvlReg[ln] <= lvlNext[ln];
          if (lineDelta[ln])
            flagReg[ln] <= 1'b1;
          else if (strobes.rdStatus)
            flagReg[ln] <= 1'b0;
        end
      end
    end
  endgenerate

  // interrupt: CTS drops out of the sources under auto-CTS
  always_comb begin
    irqMask         = '1;
    irqMask[LN_CTS] = !autoCts;
  end

  assign modemIrq = ierReg[IER_MODEM] && |(flagReg & irqMask);
  assign txAllow  = autoCts ? lvlReg[LN_CTS] : 1'b1;

  assign fillHigh = (rxFill >= trigReg);

  // registered handshake outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsN <= 1'b1;
      dtrN <= 1'b1;
    end else if (loopOn) begin
      rtsN <= 1'b1;
      dtrN <= 1'b1;
    end else begin
      rtsN <= autoRts ? fillHigh : !ctrlReg[CTRL_RTS];
      dtrN <= !ctrlReg[CTRL_DTR];
    end
  end

  // read mux
  always_comb begin
    unique case (strobes.sel)
      ADDR_CTRL: rdData = ctrlReg;
      ADDR_STAT: rdData = DATA_W'({lvlReg, flagReg});
      ADDR_IER:  rdData = ierReg;
      default:   rdData = {{PAD_W{1'b0}}, trigReg};
    endcase
  end

endmodule

// File: rtl/modem_ctrl_unit.sv
module modem_ctrl_unit
  import mcu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FILL_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_RST    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              riN,
  input  logic              dcdN,
  input  logic [FILL_W-1:0] rxFill,
  output logic              rtsN,
  output logic              dtrN,
  output logic              txAllow,
  output logic              modemIrq
);

  mcuStrobeT            strobes;
  logic [NUM_LINES-1:0] pinsN;
  logic [DATA_W-1:0]    ctrlReg;
  logic [DATA_W-1:0]    ierReg;
  logic [FILL_W-1:0]    trigReg;
  logic [NUM_LINES-1:0] flagReg;
  logic                 rdStatus;

  assign pinsN    = {dcdN, riN, dsrN, ctsN};
  assign rdStatus = strobes.rdStatus;

  mcu_ctrl uCtrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .strobes (strobes)
  );

  mcu_datapath #(
    .DATA_W      (DATA_W),
    .FILL_W      (FILL_W),
    .SYNC_STAGES (SYNC_STAGES),
    .TRIG_RST    (TRIG_RST)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .pinsN    (pinsN),
    .rxFill   (rxFill),
    .rdData   (rdData),
    .rtsN     (rtsN),
    .dtrN     (dtrN),
    .txAllow  (txAllow),
    .modemIrq (modemIrq),
    .ctrlReg  (ctrlReg),
    .ierReg   (ierReg),
    .trigReg  (trigReg),
    .flagReg  (flagReg)
  );

endmodule

// File: rtl/mcu_checker.sv
module mcu_checker #(
  parameter int DATA_W = 8,
  parameter int FILL_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] ctrlReg,
  input logic [DATA_W-1:0] ierReg,
  input logic [FILL_W-1:0] trigReg,
  input logic [3:0]        flagReg,
  input logic              rdStatus,
  input logic [FILL_W-1:0] rxFill,
  input logic              rtsN,
  input logic              dtrN,
  input logic              txAllow,
  input logic              modemIrq
);

  // R3: without a status read no flag ever drops
  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rdStatus |=> ((flagReg & $past(flagReg)) == $past(flagReg)));

  // R5: no interrupt while disabled, and only with a pending flag
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ierReg[3] |-> !modemIrq);
  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    modemIrq |-> (flagReg != 4'b0000));

  // R6: CTS alone cannot interrupt under auto-CTS; transmit free otherwise
  assert_cts_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[7] && (flagReg[3:1] == 3'b000)) |-> !modemIrq);
  assert_tx_free_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[7] |-> txAllow);

  // R7: manual outputs follow control bits one cycle later
  assert_manual_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[4] && !ctrlReg[6]) |=>
      ((dtrN == !$past(ctrlReg[0])) && (rtsN == !$past(ctrlReg[1]))));

  // R8: loop-back forces both outputs inactive
  assert_loop_inactive_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[4] |=> (rtsN && dtrN));

  // R9: auto-RTS follows the fill level against the trigger
  assert_auto_rts_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[6] && !ctrlReg[4]) |=> (rtsN == ($past(rxFill) >= $past(trigReg))));

endmodule

bind modem_ctrl_unit mcu_checker #(
  .DATA_W (DATA_W),
  .FILL_W (FILL_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ctrlReg  (ctrlReg),
  .ierReg   (ierReg),
  .trigReg  (trigReg),
  .flagReg  (flagReg),
  .rdStatus (rdStatus),
  .rxFill   (rxFill),
  .rtsN     (rtsN),
  .dtrN     (dtrN),
  .txAllow  (txAllow),
  .modemIrq (modemIrq)
);

// File: tb/sim_modem_ctrl_unit.sv
`timescale 1ns/1ps
module sim_modem_ctrl_unit;

  localparam int DATA_W = 8;
  localparam int FILL_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              ctsN = 1'b1;
  logic              dsrN = 1'b1;
  logic              riN  = 1'b1;
  logic              dcdN = 1'b1;
  logic [FILL_W-1:0] rxFill = '0;
  logic              rtsN;
  logic              dtrN;
  logic              txAllow;
  logic              modemIrq;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  modem_ctrl_unit #(.DATA_W(DATA_W), .FILL_W(FILL_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ctsN(ctsN), .dsrN(dsrN),
    .riN(riN), .dcdN(dcdN), .rxFill(rxFill), .rtsN(rtsN), .dtrN(dtrN),
    .txAllow(txAllow), .modemIrq(modemIrq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 rtsN", {7'b0, rtsN}, 8'h01);
    check("R1 dtrN", {7'b0, dtrN}, 8'h01);
    check("R1 irq", {7'b0, modemIrq}, 8'h00);
    check("R1 txAllow", {7'b0, txAllow}, 8'h01);
    rd(2'd1, v);
    check("R1 status", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd0, 8'h2C); rd(2'd0, v); check("R10 ctrl", v, 8'h2C);
    wr(2'd2, 8'h5A); rd(2'd2, v); check("R10 ier", v, 8'h5A);
    wr(2'd3, 8'h13); rd(2'd3, v); check("R10 trig", v, 8'h13);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_outputs;
    wr(2'd0, 8'h01); wait_cyc(1);
    check("R7 dtr on", {6'b0, dtrN, rtsN}, 8'h01);
    wr(2'd0, 8'h02); wait_cyc(1);
    check("R7 rts on", {6'b0, dtrN, rtsN}, 8'h02);
    wr(2'd0, 8'h03); wait_cyc(1);
    check("R7 both on", {6'b0, dtrN, rtsN}, 8'h00);
    wr(2'd0, 8'h00); wait_cyc(1);
    check("R7 both off", {6'b0, dtrN, rtsN}, 8'h03);
  endtask

  task automatic t_levels;
    logic [7:0] v;
    ctsN = 1'b0; wait_cyc(3); rd(2'd1, v); check("R2 cts low", v, 8'h11);
    dcdN = 1'b0; wait_cyc(3); rd(2'd1, v); check("R2 dcd low", v, 8'h98);
    ctsN = 1'b1; dcdN = 1'b1; dsrN = 1'b0; riN = 1'b0;
    wait_cyc(3); rd(2'd1, v); check("R2 all change", v, 8'h6F);
    dsrN = 1'b1; riN = 1'b1;
    wait_cyc(3); rd(2'd1, v); check("R2 release", v, 8'h06);
  endtask

  task automatic t_sticky;
    logic [7:0] v;
    riN = 1'b0; wait_cyc(3); rd(2'd1, v); check("R3 ri flag", v, 8'h44);
    rd(2'd1, v); check("R3 cleared by read", v, 8'h40);
    riN = 1'b1; wait_cyc(8); rd(2'd1, v); check("R3 held until read", v, 8'h04);
    rd(2'd1, v); check("R3 cleared again", v, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    dsrN = 1'b0; wait_cyc(2);
    rd(2'd1, v); check("R4 read at change edge", v, 8'h00);
    rd(2'd1, v); check("R4 flag survived", v, 8'h22);
    dsrN = 1'b1; wait_cyc(3); rd(2'd1, v); check("R4 release", v, 8'h02);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    ctsN = 1'b0; wait_cyc(3);
    check("R5 irq disabled", {7'b0, modemIrq}, 8'h00);
    wr(2'd2, 8'h08);
    check("R5 irq enabled", {7'b0, modemIrq}, 8'h01);
    rd(2'd1, v);
    check("R5 irq cleared", {7'b0, modemIrq}, 8'h00);
    ctsN = 1'b1; wait_cyc(3);
    check("R5 irq on release", {7'b0, modemIrq}, 8'h01);
    rd(2'd1, v);
  endtask

  task automatic t_autoCts;
    logic [7:0] v;
    wr(2'd0, 8'h80);
    check("R6 tx blocked", {7'b0, txAllow}, 8'h00);
    ctsN = 1'b0; wait_cyc(3);
    check("R6 tx allowed", {7'b0, txAllow}, 8'h01);
    check("R6 cts no irq", {7'b0, modemIrq}, 8'h00);
    dsrN = 1'b0; wait_cyc(3);
    check("R6 dsr irq", {7'b0, modemIrq}, 8'h01);
    rd(2'd1, v);
    ctsN = 1'b1; wait_cyc(3);
    check("R6 tx blocked again", {7'b0, txAllow}, 8'h00);
    wr(2'd0, 8'h00);
    check("R6 tx free", {7'b0, txAllow}, 8'h01);
    check("R6 pending cts irq", {7'b0, modemIrq}, 8'h01);
    rd(2'd1, v);
    dsrN = 1'b1; wait_cyc(3); rd(2'd1, v);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_loop;
    logic [7:0] v;
    wr(2'd0, 8'h16); wait_cyc(1);
    check("R8 outputs idle", {6'b0, dtrN, rtsN}, 8'h03);
    rd(2'd1, v); check("R8 levels rts aux", v, 8'h55);
    ctsN = 1'b0; dcdN = 1'b0; wait_cyc(4);
    rd(2'd1, v); check("R8 pins ignored", v, 8'h50);
    wr(2'd0, 8'h19); wait_cyc(1);
    check("R8 dtr idle", {6'b0, dtrN, rtsN}, 8'h03);
    rd(2'd1, v); check("R8 levels dtr auxb", v, 8'hAF);
    ctsN = 1'b1; dcdN = 1'b1; wait_cyc(3);
    wr(2'd0, 8'h00); wait_cyc(1);
    rd(2'd1, v); check("R8 exit loop", v, 8'h0A);
  endtask

  task automatic t_autoRts;
    wr(2'd3, 8'h04); wr(2'd0, 8'h42);
    rxFill = 5'd3; wait_cyc(1);
    check("R9 below trigger", {7'b0, rtsN}, 8'h00);
    rxFill = 5'd4; wait_cyc(1);
    check("R9 at trigger", {7'b0, rtsN}, 8'h01);
    rxFill = 5'd9; wait_cyc(1);
    check("R9 above trigger", {7'b0, rtsN}, 8'h01);
    rxFill = 5'd3; wait_cyc(1);
    check("R9 back below", {7'b0, rtsN}, 8'h00);
    wr(2'd0, 8'h40); rxFill = 5'd0; wait_cyc(1);
    check("R9 ignores rts bit", {7'b0, rtsN}, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rstN = 1'b1;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_outputs();
    t_levels();
    t_sticky();
    t_collision();
    t_irq();
    t_autoCts();
    t_loop();
    t_autoRts();
    wait_cyc(2);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule